// File: doc/BRIEF.md
# Floating-Point Classify and Scaling Unit

This unit performs the IEEE recommended helper operations on double-precision operands. It covers five operations: classification into one of ten categories, sign transfer, exponent extraction, scaling by a signed 32-bit power of two, and stepping to the adjacent representable value. It is intended to sit next to a floating-point arithmetic core. Compiled code uses it for argument reduction, range checks and robust library routines, which would otherwise need many integer instructions for each of these operations.

Each request is presented for one cycle with `in_valid`. The answer appears on the next clock edge and stays on the outputs until the next request. Scaling produces the same value and exception flags as a multiplication by the exact power of two. That includes overflow under every rounding direction and correctly rounded subnormal results. Signalling and quiet NaNs are told apart by the leading fraction bit.

Top module: `fcs_unit`

## Requirements
- R1: A request taken with `in_valid` high at a rising edge appears on `out_fp`, `out_int` and `out_flags` at that edge, with `out_valid` high for exactly that one cycle. When `in_valid` is low, all data outputs keep their values. Reset clears every output to zero. Opcodes are 0 classify, 1 copysign, 2 exponent extraction, 3 scale and 4 nextafter.
- R2: Operand `opa` (and, for copysign and nextafter, `opb`) is a NaN with fraction bit 51 clear. Such a signalling NaN sets the invalid flag (`out_flags[4]`) on every defined opcode. Any NaN result has fraction bit 51 set and keeps the rest of its payload.
- R3: A quiet NaN operand is passed to the floating-point result unchanged and raises no flag. When nextafter gets two NaN operands, it returns `opa`.
- R4: Classify returns a one-hot code on `out_int[9:0]`, with `out_fp` at zero. The bits are: 0 signalling NaN, 1 quiet NaN, 2 −infinity, 3 −normal, 4 −subnormal, 5 −zero, 6 +zero, 7 +subnormal, 8 +normal, 9 +infinity.
- R5: Copysign returns the magnitude of `opa` with the sign of `opb`.
- R6: For a finite nonzero operand, exponent extraction returns the unbiased exponent of the normalized value. It is returned as a 32-bit two's-complement integer on `out_int` and as an exact double on `out_fp`. For subnormal operands this is the true exponent, down to −1074.
- R7: Exponent extraction of ±0 returns −infinity, `out_int` = 0x80000000 and the divide-by-zero flag (`out_flags[3]`). Of ±infinity it returns +infinity and 0x7FFFFFFF, with no flag. Of a NaN it returns 0x7FFFFFFF.
- R8: Scale returns x·2^k exactly, with no flag, when the result is a normal number or an exactly representable subnormal. Zero and infinity pass through unchanged, and scaling by k = 1 equals x + x.
- R9: When a scaled result exceeds the largest finite value, scale sets overflow (`out_flags[2]`) and inexact (`out_flags[0]`). The value depends on the rounding mode `rmode`: 0 nearest-even gives infinity, 1 toward zero gives the largest finite, 2 upward gives +infinity or −largest, and 3 downward gives +largest or −infinity.
- R10: When a scaled result falls below the normal range and bits are lost, the result is rounded by `rmode`. Underflow (`out_flags[1]`) and inexact are then raised.
- R11: Nextafter returns `opb` when the operands compare equal (+0 equals −0). Otherwise it returns the neighbouring encoding of `opa` in the direction of `opb`. From zero this is the smallest subnormal with the sign of `opb`.
- R12: A nextafter result that is infinite raises overflow and inexact. A result that is subnormal or zero raises underflow and inexact. Stepping from infinity toward a finite value raises nothing.
- R13: An undefined opcode (5 to 7) gives zero on all data outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| op | input | 3 | Operation code |
| rmode | input | 2 | Rounding direction for scale |
| opa | input | 64 | First double operand |
| opb | input | 64 | Second double operand (copysign, nextafter) |
| shift_amt | input | 32 | Signed power-of-two exponent for scale |
| out_valid | output | 1 | Result strobe, one cycle after a request |
| out_fp | output | 64 | Double-precision result |
| out_int | output | 32 | Integer result (exponent or class code) |
| out_flags | output | 5 | invalid, divide-by-zero, overflow, underflow, inexact (bit 4 down to 0) |

## Verification
The properties assume that all inputs are known, non-X values whenever `in_valid` is high. They also assume that `op` is sampled in the same cycle as the operands, so the NaN and class checks can tie a request to the result one cycle later. The stimulus changes every input only on the falling clock edge and raises `in_valid` for single isolated cycles. It mostly uses the five defined opcodes and rounding codes; a single undefined opcode is sent on purpose to exercise the zero-result rule.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
    localparam int EXP_W  = 11;
    localparam int FRAC_W = 52;
    localparam int FP_W   = 1 + EXP_W + FRAC_W;
    localparam int MAN_W  = FRAC_W + 1;
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
    localparam int INT_W  = 32;
    localparam int CLS_W  = 10;
    localparam int FLG_W  = 5;
    localparam int ESUM_W = INT_W + 2;
    localparam int LZ_W   = $clog2(FRAC_W + 1);
    localparam int MAG_W  = EXP_W + 1;

    typedef enum logic [2:0] {
        OP_CLASS    = 3'd0,
        OP_COPYSIGN = 3'd1,
        OP_LOGB     = 3'd2,
        OP_SCALE    = 3'd3,
        OP_NEXT     = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        RM_NEAR_EVEN = 2'd0,
        RM_ZERO      = 2'd1,
        RM_UP        = 2'd2,
        RM_DOWN      = 2'd3
    } rmode_e;

    typedef struct packed {
        logic invalid;
        logic divzero;
        logic overflow;
        logic underflow;
        logic inexact;
    } flags_t;

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  exp;
        logic [FRAC_W-1:0] frac;
    } fp_t;

    typedef struct packed {
        logic snan;
        logic qnan;
        logic inf;
        logic norm;
        logic sub;
        logic zero;
    } kind_t;

    typedef struct packed {
        logic signed [ESUM_W-1:0] e;
        logic [MAN_W-1:0]         m;
    } norm_t;

    localparam fp_t POS_INF = '{1'b0, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    localparam fp_t NEG_INF = '{1'b1, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    localparam logic [INT_W-1:0] INT_MAX = {1'b0, {(INT_W-1){1'b1}}};
    localparam logic [INT_W-1:0] INT_MIN = {1'b1, {(INT_W-1){1'b0}}};

    function automatic kind_t kind_of(fp_t x);
        kind_t k;
        logic e_max  = &x.exp;
        logic e_zero = ~|x.exp;
        logic f_zero = ~|x.frac;
        k.snan = e_max & ~f_zero & ~x.frac[FRAC_W-1];
        k.qnan = e_max & x.frac[FRAC_W-1];
        k.inf  = e_max & f_zero;
        k.norm = ~e_max & ~e_zero;
        k.sub  = e_zero & ~f_zero;
        k.zero = e_zero & f_zero;
        return k;
    endfunction

    function automatic fp_t quieten(fp_t x);
        fp_t r = x;
        r.frac[FRAC_W-1] = 1'b1;
        return r;
    endfunction

    function automatic logic [LZ_W-1:0] lead_zeros(logic [FRAC_W-1:0] f);
        logic [LZ_W-1:0] n = LZ_W'(FRAC_W);
        for (int i = 0; i < FRAC_W; i++)
            if (f[i]) n = LZ_W'(FRAC_W - 1 - i);
        return n;
    endfunction

    // Unbiased exponent and 53-bit significand with the leading one at the top.
    function automatic norm_t norm_of(fp_t x);
        norm_t r;
        logic [LZ_W-1:0] lz = lead_zeros(x.frac);
        if (|x.exp) begin
            r.e = ESUM_W'(x.exp) - ESUM_W'(BIAS);
            r.m = {1'b1, x.frac};
        end else begin
            r.e = -ESUM_W'(BIAS) - ESUM_W'(lz);
            r.m = {1'b0, x.frac} << (lz + 1'b1);
        end
        return r;
    endfunction

    function automatic logic round_inc(rmode_e rm, logic sign, logic lsb, logic g, logic st);
        case (rm)
            RM_NEAR_EVEN: return g & (st | lsb);
            RM_ZERO:      return 1'b0;
            RM_UP:        return (g | st) & ~sign;
            default:      return (g | st) & sign;
        endcase
    endfunction

    function automatic fp_t ovf_value(logic sign, rmode_e rm);
        fp_t r;
        logic to_inf = (rm == RM_NEAR_EVEN) | ((rm == RM_UP) & ~sign) | ((rm == RM_DOWN) & sign);
        r.sign = sign;
        r.exp  = to_inf ? {EXP_W{1'b1}} : {{(EXP_W-1){1'b1}}, 1'b0};
        r.frac = to_inf ? {FRAC_W{1'b0}} : {FRAC_W{1'b1}};
        return r;
    endfunction

    function automatic logic fp_equal(fp_t a, fp_t b);
        return (a == b) || (~|{a.exp, a.frac} && ~|{b.exp, b.frac});
    endfunction

    function automatic logic fp_less(fp_t a, fp_t b);
        logic [FP_W-2:0] ma = {a.exp, a.frac};
        logic [FP_W-2:0] mb = {b.exp, b.frac};
        if (~|ma && ~|mb) return 1'b0;
        if (a.sign != b.sign) return a.sign;
        return a.sign ? (ma > mb) : (ma < mb);
    endfunction
endpackage

// File: rtl/fcs_scale.sv
module fcs_scale
    import fcs_pkg::*;
(
    input  fp_t                      x,
    input  logic signed [INT_W-1:0]  k,
    input  rmode_e                   rm,
    output fp_t                      res,
    output flags_t                   fl
);
    localparam int GRD_W  = MAN_W + 3;
    localparam int SH_MAX = MAN_W + 2;
    localparam int SH_W   = $clog2(SH_MAX + 1);
    localparam logic signed [ESUM_W-1:0] E_TOP = ESUM_W'(BIAS);
    localparam logic signed [ESUM_W-1:0] E_BOT = ESUM_W'(1 - BIAS);
    localparam logic signed [ESUM_W-1:0] SH_LIM = ESUM_W'(SH_MAX);

    kind_t                     kd;
    norm_t                     nx;
    logic signed [ESUM_W-1:0]  e_new;
    logic signed [ESUM_W-1:0]  gap;
    logic [SH_W-1:0]           sh;
    logic [MAN_W+GRD_W-1:0]    ext;
    logic [MAN_W-1:0]          kept;
    logic [MAN_W-1:0]          sub_m;
    logic                      guard, sticky, inc;

    always_comb begin
        kd     = kind_of(x);
        nx     = norm_of(x);
        e_new  = nx.e + ESUM_W'(k);
        gap    = E_BOT - e_new;
        sh     = (gap > SH_LIM) ? SH_W'(SH_MAX) : SH_W'(gap);
        ext    = {nx.m, {GRD_W{1'b0}}} >> sh;
        kept   = ext[MAN_W+GRD_W-1 -: MAN_W];
        guard  = ext[GRD_W-1];
        sticky = |ext[GRD_W-2:0];
        inc    = round_inc(rm, x.sign, kept[0], guard, sticky);
        sub_m  = kept + MAN_W'(inc);
        res    = x;
        fl     = '0;
        if (kd.snan) begin
            res        = quieten(x);
            fl.invalid = 1'b1;
        end else if (kd.qnan | kd.inf | kd.zero) begin
            res = x;
        end else if (e_new > E_TOP) begin
            res         = ovf_value(x.sign, rm);
            fl.overflow = 1'b1;
            fl.inexact  = 1'b1;
        end else if (e_new >= E_BOT) begin
            res.exp  = EXP_W'(e_new + E_TOP);
            res.frac = nx.m[FRAC_W-1:0];
        end else begin
            res          = {x.sign, {(EXP_W + FRAC_W - MAN_W){1'b0}}, sub_m};
            fl.underflow = guard | sticky;
            fl.inexact   = guard | sticky;
        end
    end
endmodule

// File: rtl/fcs_logb.sv
module fcs_logb
    import fcs_pkg::*;
(
    input  fp_t               x,
    output fp_t               res,
    output logic [INT_W-1:0]  ires,
    output flags_t            fl,
    output logic [CLS_W-1:0]  cls
);
    kind_t            kd;
    norm_t            nx;
    logic [MAG_W-1:0] mag;
    logic [LZ_W-1:0]  top;
    logic [FRAC_W:0]  wide;

    always_comb begin
        kd  = kind_of(x);
        nx  = norm_of(x);
        mag = nx.e[ESUM_W-1] ? MAG_W'(-nx.e) : MAG_W'(nx.e);
        top = '0;
        for (int i = 0; i < MAG_W; i++)
            if (mag[i]) top = LZ_W'(i);
        wide = {{(FRAC_W + 1 - MAG_W){1'b0}}, mag} << (LZ_W'(FRAC_W) - top);
        res  = '0;
        ires = '0;
        fl   = '0;
        if (kd.snan | kd.qnan) begin
            res        = quieten(x);
            ires       = INT_MAX;
            fl.invalid = kd.snan;
        end else if (kd.inf) begin
            res  = POS_INF;
            ires = INT_MAX;
        end else if (kd.zero) begin
            res        = NEG_INF;
            ires       = INT_MIN;
            fl.divzero = 1'b1;
        end else begin
            ires = INT_W'(nx.e);
            if (|mag) begin
                res.sign = nx.e[ESUM_W-1];
                res.exp  = EXP_W'(BIAS) + EXP_W'(top);
                res.frac = wide[FRAC_W-1:0];
            end
        end
        cls    = '0;
        cls[0] = kd.snan;
        cls[1] = kd.qnan;
        cls[2] = kd.inf  &  x.sign;
        cls[3] = kd.norm &  x.sign;
        cls[4] = kd.sub  &  x.sign;
        cls[5] = kd.zero &  x.sign;
        cls[6] = kd.zero & ~x.sign;
        cls[7] = kd.sub  & ~x.sign;
        cls[8] = kd.norm & ~x.sign;
        cls[9] = kd.inf  & ~x.sign;
    end
endmodule

// File: rtl/fcs_step.sv
module fcs_step
    import fcs_pkg::*;
(
    input  fp_t    x,
    input  fp_t    y,
    output fp_t    res,
    output flags_t fl
);
    kind_t           kx, ky;
    logic [FP_W-2:0] mag;
    logic            grow;

    always_comb begin
        kx   = kind_of(x);
        ky   = kind_of(y);
        grow = fp_less(x, y) ^ x.sign;
        mag  = grow ? ({x.exp, x.frac} + 1'b1) : ({x.exp, x.frac} - 1'b1);
        res  = x;
        fl   = '0;
        if (kx.snan | kx.qnan | ky.snan | ky.qnan) begin
            res        = (kx.snan | kx.qnan) ? quieten(x) : quieten(y);
            fl.invalid = kx.snan | ky.snan;
        end else if (fp_equal(x, y)) begin
            res = y;
        end else if (kx.zero) begin
            res          = {y.sign, {(FP_W-2){1'b0}}, 1'b1};
            fl.underflow = 1'b1;
            fl.inexact   = 1'b1;
        end else begin
            res = {x.sign, mag};
            if (&mag[FP_W-2 -: EXP_W]) begin
                fl.overflow = 1'b1;
                fl.inexact  = 1'b1;
            end else if (~|mag[FP_W-2 -: EXP_W]) begin
                fl.underflow = 1'b1;
                fl.inexact   = 1'b1;
            end
        end
    end
endmodule

// File: rtl/fcs_unit.sv
module fcs_unit
    import fcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [2:0]        op,
    input  logic [1:0]        rmode,
    input  logic [FP_W-1:0]   opa,
    input  logic [FP_W-1:0]   opb,
    input  logic [INT_W-1:0]  shift_amt,
    output logic              out_valid,
    output logic [FP_W-1:0]   out_fp,
    output logic [INT_W-1:0]  out_int,
    output logic [FLG_W-1:0]  out_flags
);
    fp_t    a, b;
    op_e    opc;
    rmode_e rm;
    kind_t  ka, kb;

    assign a   = fp_t'(opa);
    assign b   = fp_t'(opb);
    assign opc = op_e'(op);
    assign rm  = rmode_e'(rmode);
    assign ka  = kind_of(a);
    assign kb  = kind_of(b);

    fp_t              sc_res, lg_res, st_res;
    flags_t           sc_fl, lg_fl, st_fl;
    logic [INT_W-1:0] lg_int;
    logic [CLS_W-1:0] lg_cls;

    fcs_scale u_scale (
        .x   (a),
        .k   (shift_amt),
        .rm  (rm),
        .res (sc_res),
        .fl  (sc_fl)
    );

    fcs_logb u_logb (
        .x    (a),
        .res  (lg_res),
        .ires (lg_int),
        .fl   (lg_fl),
        .cls  (lg_cls)
    );

    fcs_step u_step (
        .x   (a),
        .y   (b),
        .res (st_res),
        .fl  (st_fl)
    );

    fp_t              nxt_fp;
    logic [INT_W-1:0] nxt_int;
    flags_t           nxt_fl;

    always_comb begin
        nxt_fp  = '0;
        nxt_int = '0;
        nxt_fl  = '0;
        case (opc)
            OP_CLASS: begin
                nxt_int        = INT_W'(lg_cls);
                nxt_fl.invalid = ka.snan;
            end
            OP_COPYSIGN: begin
                nxt_fp         = ka.snan ? quieten(a) : a;
                nxt_fp.sign    = b.sign;
                nxt_fl.invalid = ka.snan | kb.snan;
            end
            OP_LOGB: begin
                nxt_fp  = lg_res;
                nxt_int = lg_int;
                nxt_fl  = lg_fl;
            end
            OP_SCALE: begin
                nxt_fp = sc_res;
                nxt_fl = sc_fl;
            end
            OP_NEXT: begin
                nxt_fp = st_res;
                nxt_fl = st_fl;
            end
            default: begin
                nxt_fp = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_fp    <= '0;
            out_int   <= '0;
            out_flags <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_fp    <= nxt_fp;
                out_int   <= nxt_int;
                out_flags <= nxt_fl;
            end
        end
    end
endmodule

// File: rtl/fcs_unit_chk.sv
module fcs_unit_chk
    import fcs_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [2:0]        op,
    input logic [FP_W-1:0]   opa,
    input logic [FP_W-1:0]   opb,
    input logic              out_valid,
    input logic [FP_W-1:0]   out_fp,
    input logic [INT_W-1:0]  out_int,
    input logic [FLG_W-1:0]  out_flags
);
    logic a_snan, a_qnan, b_snan, out_nan;
    assign a_snan  = (&opa[FP_W-2:FRAC_W]) && (|opa[FRAC_W-1:0]) && !opa[FRAC_W-1];
    assign a_qnan  = (&opa[FP_W-2:FRAC_W]) && opa[FRAC_W-1];
    assign b_snan  = (&opb[FP_W-2:FRAC_W]) && (|opb[FRAC_W-1:0]) && !opb[FRAC_W-1];
    assign out_nan = (&out_fp[FP_W-2:FRAC_W]) && (|out_fp[FRAC_W-1:0]);

    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    // R1
    valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R1
    hold_result_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_fp) && $stable(out_int) && $stable(out_flags)));
    // R2
    snan_invalid_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op <= 3'd4 && a_snan) |=> out_flags[4]);
    // R2
    nan_out_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_nan) |-> out_fp[FRAC_W-1]);
    // R3
    qnan_silent_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && a_qnan && !b_snan) |=> (out_flags == '0));
    // R4
    class_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 3'd0) |=> ($countones(out_int) == 1));
    // R9
    range_inexact_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && (out_flags[2] || out_flags[1])) |-> out_flags[0]);
endmodule

bind fcs_unit fcs_unit_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .op        (op),
    .opa       (opa),
    .opb       (opb),
    .out_valid (out_valid),
    .out_fp    (out_fp),
    .out_int   (out_int),
    .out_flags (out_flags)
);

// File: tb/sim_fcs_unit.sv
module sim_fcs_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [2:0]  op;
    logic [1:0]  rmode;
    logic [63:0] opa, opb;
    logic [31:0] shift_amt;
    logic        out_valid;
    logic [63:0] out_fp;
    logic [31:0] out_int;
    logic [4:0]  out_flags;

    int n_cmp = 0;
    int n_bad = 0;

    localparam logic [4:0] F_NONE = 5'b00000;
    localparam logic [4:0] F_INV  = 5'b10000;
    localparam logic [4:0] F_DZ   = 5'b01000;
    localparam logic [4:0] F_OVX  = 5'b00101;
    localparam logic [4:0] F_UFX  = 5'b00011;

    localparam logic [63:0] ONE   = 64'h3FF0000000000000;
    localparam logic [63:0] MONE  = 64'hBFF0000000000000;
    localparam logic [63:0] PINF  = 64'h7FF0000000000000;
    localparam logic [63:0] NINF  = 64'hFFF0000000000000;
    localparam logic [63:0] PMAX  = 64'h7FEFFFFFFFFFFFFF;
    localparam logic [63:0] NMAX  = 64'hFFEFFFFFFFFFFFFF;

    always #4 clk = ~clk;

    fcs_unit u0 (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .op        (op),
        .rmode     (rmode),
        .opa       (opa),
        .opb       (opb),
        .shift_amt (shift_amt),
        .out_valid (out_valid),
        .out_fp    (out_fp),
        .out_int   (out_int),
        .out_flags (out_flags)
    );

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic chk(input string msg, input logic [127:0] got, input logic [127:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", msg, got, exp);
        end
    endtask

    task automatic run(input logic [2:0] o, input logic [1:0] r, input logic [63:0] a,
                       input logic [63:0] b, input logic [31:0] k);
        @(negedge clk);
        op = o; rmode = r; opa = a; opb = b; shift_amt = k; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic exp_fp(input string msg, input logic [63:0] efp, input logic [4:0] efl);
        chk(msg, {out_valid, out_fp, 3'b0, out_flags}, {1'b1, efp, 3'b0, efl});
    endtask

    task automatic exp_int(input string msg, input logic [31:0] ei, input logic [4:0] efl);
        chk(msg, {out_valid, out_int, out_flags}, {1'b1, ei, efl});
    endtask

    task automatic t_reset();
        rst = 1'b1; in_valid = 1'b0; op = '0; rmode = '0; opa = '0; opb = '0; shift_amt = '0;
        repeat (3) @(negedge clk);
        chk("R1 reset clears outputs", {out_valid, out_fp, out_int, out_flags}, '0);
        rst = 1'b0;
    endtask

    task automatic t_classify();
        run(0, 0, ONE, 0, 0);                    exp_int("R4 +normal", 32'h100, F_NONE);
        chk("R4 classify fp zero", out_fp, 0);
        run(0, 0, 64'h8000000000000000, 0, 0);   exp_int("R4 -zero", 32'h20, F_NONE);
        run(0, 0, 64'h0, 0, 0);                  exp_int("R4 +zero", 32'h40, F_NONE);
        run(0, 0, 64'h0000000000000005, 0, 0);   exp_int("R4 +subnormal", 32'h80, F_NONE);
        run(0, 0, 64'h8000000000000005, 0, 0);   exp_int("R4 -subnormal", 32'h10, F_NONE);
        run(0, 0, MONE, 0, 0);                   exp_int("R4 -normal", 32'h8, F_NONE);
        run(0, 0, NINF, 0, 0);                   exp_int("R4 -inf", 32'h4, F_NONE);
        run(0, 0, PINF, 0, 0);                   exp_int("R4 +inf", 32'h200, F_NONE);
        run(0, 0, 64'h7FF8000000000000, 0, 0);   exp_int("R4 R3 qNaN", 32'h2, F_NONE);
        run(0, 0, 64'h7FF0000000000001, 0, 0);   exp_int("R4 R2 sNaN", 32'h1, F_INV);
    endtask

    task automatic t_copysign();
        run(1, 0, ONE, 64'hC000000000000000, 0);             exp_fp("R5 negative sign", MONE, F_NONE);
        run(1, 0, NINF, 64'h0, 0);                           exp_fp("R5 inf to positive", PINF, F_NONE);
        run(1, 0, 64'h7FF0000000000001, MONE, 0);            exp_fp("R5 R2 sNaN quietened", 64'hFFF8000000000001, F_INV);
    endtask

    task automatic t_logb();
        run(2, 0, $realtobits(8.0), 0, 0);
        exp_fp("R6 logb 8 double", $realtobits(3.0), F_NONE);  exp_int("R6 logb 8 int", 32'd3, F_NONE);
        run(2, 0, $realtobits(-0.5), 0, 0);
        exp_fp("R6 logb -0.5 double", $realtobits(-1.0), F_NONE); exp_int("R6 logb -0.5 int", -32'sd1, F_NONE);
        run(2, 0, 64'h1, 0, 0);
        exp_fp("R6 logb min subnormal", $realtobits(-1074.0), F_NONE); exp_int("R6 min subnormal int", -32'sd1074, F_NONE);
        run(2, 0, ONE, 0, 0);
        exp_fp("R6 logb 1 double", 64'h0, F_NONE); exp_int("R6 logb 1 int", 32'd0, F_NONE);
        run(2, 0, 64'h8000000000000000, 0, 0);
        exp_fp("R7 logb zero", NINF, F_DZ); exp_int("R7 logb zero int", 32'h80000000, F_DZ);
        run(2, 0, NINF, 0, 0);
        exp_fp("R7 logb inf", PINF, F_NONE); exp_int("R7 logb inf int", 32'h7FFFFFFF, F_NONE);
        run(2, 0, 64'h7FF0000000000010, 0, 0);
        exp_fp("R7 R2 logb sNaN", 64'h7FF8000000000010, F_INV); exp_int("R7 logb NaN int", 32'h7FFFFFFF, F_INV);
    endtask

    task automatic t_scale_range();
        run(3, 0, $realtobits(1.5), 0, 32'd10);          exp_fp("R8 1.5*2^10", $realtobits(1536.0), F_NONE);
        run(3, 0, $realtobits(-3.25), 0, 32'd1);         exp_fp("R8 scale by 1 equals x+x", $realtobits(-6.5), F_NONE);
        run(3, 0, 64'h1, 0, 32'd1074);                   exp_fp("R8 subnormal input to 1.0", ONE, F_NONE);
        run(3, 0, ONE, 0, -32'sd1074);                   exp_fp("R8 exact min subnormal", 64'h1, F_NONE);
        run(3, 0, $realtobits(3.0), 0, -32'sd1074);      exp_fp("R8 exact subnormal 3", 64'h3, F_NONE);
        run(3, 0, 64'h8000000000000000, 0, 32'd5);       exp_fp("R8 zero passes", 64'h8000000000000000, F_NONE);
        run(3, 0, NINF, 0, -32'sd3);                     exp_fp("R8 inf passes", NINF, F_NONE);
    endtask

    task automatic t_scale_over();
        run(3, 0, ONE, 0, 32'd2000);   exp_fp("R9 nearest to +inf", PINF, F_OVX);
        run(3, 1, ONE, 0, 32'd2000);   exp_fp("R9 toward zero max", PMAX, F_OVX);
        run(3, 2, MONE, 0, 32'd2000);  exp_fp("R9 upward negative max", NMAX, F_OVX);
        run(3, 3, MONE, 0, 32'd2000);  exp_fp("R9 downward negative inf", NINF, F_OVX);
        run(3, 3, ONE, 0, 32'h7FFFFFFF); exp_fp("R9 downward positive max", PMAX, F_OVX);
    endtask

    task automatic t_scale_under();
        run(3, 0, ONE, 0, -32'sd1075);          exp_fp("R10 tie to even zero", 64'h0, F_UFX);
        run(3, 2, ONE, 0, -32'sd1075);          exp_fp("R10 upward half ulp", 64'h1, F_UFX);
        run(3, 0, $realtobits(1.5), 0, -32'sd1075); exp_fp("R10 nearest 0.75 ulp", 64'h1, F_UFX);
        run(3, 1, $realtobits(1.5), 0, -32'sd1075); exp_fp("R10 toward zero 0.75 ulp", 64'h0, F_UFX);
        run(3, 3, MONE, 0, 32'h80000000);       exp_fp("R10 downward huge shift", 64'h8000000000000001, F_UFX);
        run(3, 0, ONE, 0, 32'h80000000);        exp_fp("R10 nearest huge shift", 64'h0, F_UFX);
    endtask

    task automatic t_next();
        run(4, 0, ONE, $realtobits(2.0), 0);      exp_fp("R11 up from 1", 64'h3FF0000000000001, F_NONE);
        run(4, 0, ONE, 64'h0, 0);                 exp_fp("R11 down from 1", 64'h3FEFFFFFFFFFFFFF, F_NONE);
        run(4, 0, MONE, $realtobits(-2.0), 0);    exp_fp("R11 negative away", 64'hBFF0000000000001, F_NONE);
        run(4, 0, 64'h8000000000000000, 64'h0, 0); exp_fp("R11 equal zeros return y", 64'h0, F_NONE);
        run(4, 0, 64'h0, MONE, 0);                exp_fp("R11 R12 zero toward negative", 64'h8000000000000001, F_UFX);
        run(4, 0, PMAX, PINF, 0);                 exp_fp("R12 step to inf", PINF, F_OVX);
        run(4, 0, 64'h0010000000000000, 64'h0, 0); exp_fp("R12 step to subnormal", 64'h000FFFFFFFFFFFFF, F_UFX);
        run(4, 0, PINF, 64'h0, 0);                exp_fp("R12 inf to max silent", PMAX, F_NONE);
    endtask

    task automatic t_nan();
        run(3, 0, 64'h7FF8000000000123, 0, 32'd5);  exp_fp("R3 scale qNaN", 64'h7FF8000000000123, F_NONE);
        run(3, 0, 64'h7FF0000000000123, 0, 32'd5);  exp_fp("R2 scale sNaN", 64'h7FF8000000000123, F_INV);
        run(4, 0, ONE, 64'hFFF4000000000000, 0);    exp_fp("R2 next sNaN y", 64'hFFFC000000000000, F_INV);
        run(4, 0, 64'h7FF8000000000007, 64'h7FF0000000000009, 0);
        exp_fp("R2 R3 next returns opa NaN", 64'h7FF8000000000007, F_INV);
        run(4, 0, 64'hFFF8000000000002, ONE, 0);    exp_fp("R3 next qNaN x", 64'hFFF8000000000002, F_NONE);
    endtask

    task automatic t_misc();
        run(7, 0, ONE, ONE, 32'd3);
        chk("R13 undefined opcode", {out_valid, out_fp, out_int, out_flags}, {1'b1, 101'b0});
        run(3, 0, ONE, 0, 32'd1);
        exp_fp("R1 latency one cycle", $realtobits(2.0), F_NONE);
        opa = MONE; shift_amt = 32'd7;
        @(negedge clk);
        chk("R1 out_valid drops", {31'b0, out_valid}, 0);
        chk("R1 result held", out_fp, $realtobits(2.0));
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        t_reset();
        t_classify();
        t_copysign();
        t_logb();
        t_scale_range();
        t_scale_over();
        t_scale_under();
        t_next();
        t_nan();
        t_misc();
        summary();
        $finish;
    end
endmodule